// File: doc/BRIEF.md
# Pairwise Floating-Point Min/Max Reducer

This unit takes two 64-bit source vectors and returns one 64-bit vector in which every result lane is the minimum or the maximum of two neighbouring lanes of one source. The pairs of the first source fill the low half of the result and the pairs of the second source fill the high half. One control input picks maximum or minimum. A second control input picks the lane format: two 32-bit single-precision lanes or four 16-bit half-precision lanes per vector.

Comparisons always run in one fixed arithmetic mode. Subnormal operands count as zero of the same sign. Any NaN operand gives the canonical quiet NaN. Negative zero ranks below positive zero. A sticky-free invalid flag reports signalling NaN operands. A small field decoder rejects illegal control combinations with an undefined flag. The datapath is combinational and the result is registered, so the result appears one clock after a valid request.

Top module: `pmm_unit`

## Requirements
- R1: With size_half=0, out_data[31:0] is the selected min/max of src_a[31:0] and src_a[63:32], and out_data[63:32] is the same function of src_b[31:0] and src_b[63:32].
- R2: With size_half=1, out_data[15:0], [31:16], [47:32] and [63:48] are the min/max of src_a lanes (0,1), src_a lanes (2,3), src_b lanes (0,1) and src_b lanes (2,3), where lane k occupies bits [16k+15:16k].
- R3: op_min=0 selects the maximum of each pair and op_min=1 selects the minimum.
- R4: If either operand of a pair is a NaN (exponent all ones, mantissa nonzero), that result lane is 0x7FC00000 in 32-bit lanes or 0x7E00 in 16-bit lanes.
- R5: An operand with a zero exponent field is treated as a zero of its own sign, and when chosen it is returned as that signed zero.
- R6: Negative zero ranks below positive zero: the minimum of the two zeros is the negative one and the maximum is the positive one.
- R7: out_invalid is 1 for a defined request exactly when at least one operand in the selected format is a signalling NaN (a NaN whose mantissa top bit is 0).
- R8: q_bit=1 marks the request undefined: out_undef=1, out_data=0 and out_invalid=0.
- R9: size_half=1 with fp16_present=0 is undefined (same outputs as R8); size_half=0 is defined whatever fp16_present is.
- R10: out_valid is 1 in the cycle after a clock edge with in_valid=1 and 0 otherwise; reset clears out_valid, out_undef, out_invalid and out_data.
- R11: While in_valid=0 the registered out_data, out_undef and out_invalid keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present this cycle |
| src_a | input | 64 | First source vector |
| src_b | input | 64 | Second source vector |
| op_min | input | 1 | 0 = maximum, 1 = minimum |
| size_half | input | 1 | 0 = two 32-bit lanes, 1 = four 16-bit lanes |
| q_bit | input | 1 | Quad-width request field; 1 is illegal |
| fp16_present | input | 1 | Half-precision support is available |
| out_valid | output | 1 | Registered result valid |
| out_data | output | 64 | Registered result vector |
| out_undef | output | 1 | Request was undefined |
| out_invalid | output | 1 | A signalling NaN operand was compared |

## Verification
The hardest situation to reach is a pair in which a subnormal and a zero of the opposite sign meet, because the correct result depends on flushing first and then applying the signed-zero order; directed vectors build exactly these pairs in both lane formats and for both operations. A signalling NaN placed in the format that is not selected (for example in the upper half of a 32-bit lane while running in 16-bit mode reads as a different value) is also steered deliberately so that the invalid flag is seen to follow only the chosen format. A random phase draws each lane from a pool of normals, infinities, signed zeros, subnormals and both NaN kinds and compares every lane to a bench-side model.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
   // Lane format selector values
   typedef enum logic {
      FMT_SINGLE = 1'b0,
      FMT_HALF   = 1'b1
   } pmm_fmt_e;

   // Result of the field decoder
   typedef struct packed {
      logic undef;
      logic want_max;
      logic half;
   } pmm_ctl_t;
endpackage

// File: rtl/pmm_lane_cmp.sv
module pmm_lane_cmp #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] op_x,
   input  logic [EXP_W+MAN_W:0] op_y,
   input  logic                 want_max,
   output logic [EXP_W+MAN_W:0] res,
   output logic                 sig_nan
);
   localparam int W = 1 + EXP_W + MAN_W;
   localparam logic [W-1:0] DNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   function automatic logic is_nan(input logic [W-1:0] v);
      return (&v[W-2:MAN_W]) && (|v[MAN_W-1:0]);
   endfunction

   function automatic logic [W-1:0] flush(input logic [W-1:0] v);
      return (v[W-2:MAN_W] == '0) ? {v[W-1], {(W-1){1'b0}}} : v;
   endfunction

   // Monotonic unsigned key: negative values inverted, positive get top bit set
   function automatic logic [W-1:0] order_key(input logic [W-1:0] v);
      return v[W-1] ? ~v : {1'b1, v[W-2:0]};
   endfunction

   logic [W-1:0] fx, fy;
   logic         y_above;
   logic         any_nan;

   always_comb begin
      fx      = flush(op_x);
      fy      = flush(op_y);
      y_above = order_key(fy) > order_key(fx);
      any_nan = is_nan(op_x) || is_nan(op_y);
      sig_nan = (is_nan(op_x) && !op_x[MAN_W-1]) || (is_nan(op_y) && !op_y[MAN_W-1]);
      if (any_nan)       res = DNAN;
      else if (want_max) res = y_above ? fy : fx;
      else               res = y_above ? fx : fy;
   end
endmodule

// File: rtl/pmm_pair_reduce.sv
module pmm_pair_reduce #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int VEC_W = 64
) (
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic             want_max,
   output logic [VEC_W-1:0] res,
   output logic             inv
);
   localparam int LW    = 1 + EXP_W + MAN_W;
   localparam int LANES = VEC_W / LW;
   localparam int HALF  = LANES / 2;

   logic [VEC_W-1:0] srcs [2];
   logic [LANES-1:0] inv_v;

   assign srcs[0] = src_a;
   assign srcs[1] = src_b;

   for (genvar s = 0; s < 2; s++) begin : g_src
      for (genvar e = 0; e < HALF; e++) begin : g_pair
         pmm_lane_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cmp_i (
            .op_x     (srcs[s][(2*e)*LW +: LW]),
            .op_y     (srcs[s][(2*e+1)*LW +: LW]),
            .want_max (want_max),
            .res      (res[(s*HALF+e)*LW +: LW]),
            .sig_nan  (inv_v[s*HALF+e])
         );
      end
   end

   if (LANES * LW < VEC_W) begin : g_pad
      assign res[VEC_W-1:LANES*LW] = '0;
   end

   assign inv = |inv_v;
endmodule

// File: rtl/pmm_decode.sv
module pmm_decode
   import pmm_pkg::*;
(
   input  logic     q_bit,
   input  logic     size_half,
   input  logic     op_min,
   input  logic     fp16_present,
   output pmm_ctl_t ctl
);
   always_comb begin
      ctl.half     = (pmm_fmt_e'(size_half) == FMT_HALF);
      ctl.want_max = !op_min;
      ctl.undef    = q_bit || (ctl.half && !fp16_present);
   end
endmodule

// File: rtl/pmm_unit.sv
module pmm_unit
   import pmm_pkg::*;
#(
   parameter int VEC_W  = 64,
   parameter int SP_EXP = 8,
   parameter int SP_MAN = 23,
   parameter int HP_EXP = 5,
   parameter int HP_MAN = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic             op_min,
   input  logic             size_half,
   input  logic             q_bit,
   input  logic             fp16_present,
   output logic             out_valid,
   output logic [VEC_W-1:0] out_data,
   output logic             out_undef,
   output logic             out_invalid
);
   localparam int SP_W = 1 + SP_EXP + SP_MAN;
   localparam int HP_W = 1 + HP_EXP + HP_MAN;

   if (VEC_W % (2 * SP_W) != 0) begin : g_bad_sp
      $error("VEC_W must hold an even number of single lanes");
   end
   if (VEC_W % (2 * HP_W) != 0) begin : g_bad_hp
      $error("VEC_W must hold an even number of half lanes");
   end
   if (SP_MAN < 2 || HP_MAN < 2) begin : g_bad_man
      $error("mantissa fields need at least two bits");
   end

   pmm_ctl_t         ctl;
   logic [VEC_W-1:0] sp_res, hp_res;
   logic             sp_inv, hp_inv;

   pmm_decode dec_i (
      .q_bit        (q_bit),
      .size_half    (size_half),
      .op_min       (op_min),
      .fp16_present (fp16_present),
      .ctl          (ctl)
   );

   pmm_pair_reduce #(.EXP_W(SP_EXP), .MAN_W(SP_MAN), .VEC_W(VEC_W)) sp_i (
      .src_a (src_a), .src_b (src_b), .want_max (ctl.want_max),
      .res   (sp_res), .inv (sp_inv)
   );

   pmm_pair_reduce #(.EXP_W(HP_EXP), .MAN_W(HP_MAN), .VEC_W(VEC_W)) hp_i (
      .src_a (src_a), .src_b (src_b), .want_max (ctl.want_max),
      .res   (hp_res), .inv (hp_inv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_undef   <= 1'b0;
         out_invalid <= 1'b0;
         out_data    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_undef   <= ctl.undef;
            out_invalid <= !ctl.undef && (ctl.half ? hp_inv : sp_inv);
            out_data    <= ctl.undef ? '0 : (ctl.half ? hp_res : sp_res);
         end
      end
   end
endmodule

// File: rtl/pmm_unit_chk.sv
module pmm_unit_chk #(
   parameter int VEC_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [VEC_W-1:0] src_a,
   input logic [VEC_W-1:0] src_b,
   input logic             size_half,
   input logic             q_bit,
   input logic             fp16_present,
   input logic             out_valid,
   input logic [VEC_W-1:0] out_data,
   input logic             out_undef,
   input logic             out_invalid
);
   // R10
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R10
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R8
   q_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && q_bit) |=> (out_undef && out_data == '0 && !out_invalid));
   // R9
   fp16_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_half && !fp16_present) |=> out_undef);
   // R9
   single_defined_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !q_bit && !size_half) |=> !out_undef);
   // R11
   hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_undef) && $stable(out_invalid)));
   // R7
   no_nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !size_half && !(&src_a[30:23]) && !(&src_a[62:55])
       && !(&src_b[30:23]) && !(&src_b[62:55])) |=> !out_invalid);
endmodule

bind pmm_unit pmm_unit_chk #(.VEC_W(VEC_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .src_a        (src_a),
   .src_b        (src_b),
   .size_half    (size_half),
   .q_bit        (q_bit),
   .fp16_present (fp16_present),
   .out_valid    (out_valid),
   .out_data     (out_data),
   .out_undef    (out_undef),
   .out_invalid  (out_invalid)
);

// File: tb/pmm_unit_tb.sv
module pmm_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] src_a = '0, src_b = '0;
   logic        op_min = 1'b0, size_half = 1'b0, q_bit = 1'b0, fp16_present = 1'b1;
   logic        out_valid, out_undef, out_invalid;
   logic [63:0] out_data;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pmm_unit dut_i (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
      .src_a (src_a), .src_b (src_b), .op_min (op_min),
      .size_half (size_half), .q_bit (q_bit), .fp16_present (fp16_present),
      .out_valid (out_valid), .out_data (out_data),
      .out_undef (out_undef), .out_invalid (out_invalid)
   );

   task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
      end
   endtask

   // Bench-side model of one pair, written from the requirements
   function automatic logic [31:0] ref_lane(input logic [31:0] x, input logic [31:0] y,
                                            input bit mx, input int ew, input int mw,
                                            output bit sn);
      int w;
      logic [31:0] emask, mmask, smask, ex, ey, dnan, magx, magy;
      bit nx, ny, sx, sy, x_less;
      w     = 1 + ew + mw;
      emask = (32'd1 << ew) - 1;
      mmask = (32'd1 << mw) - 1;
      smask = 32'd1 << (w - 1);
      ex    = (x >> mw) & emask;
      ey    = (y >> mw) & emask;
      nx    = (ex == emask) && ((x & mmask) != 0);
      ny    = (ey == emask) && ((y & mmask) != 0);
      sn    = (nx && ((x >> (mw - 1)) & 1) == 0) || (ny && ((y >> (mw - 1)) & 1) == 0);
      dnan  = (emask << mw) | (32'd1 << (mw - 1));
      if (nx || ny) return dnan;
      if (ex == 0) x = x & smask;
      if (ey == 0) y = y & smask;
      sx   = (x & smask) != 0;
      sy   = (y & smask) != 0;
      magx = x & (smask - 1);
      magy = y & (smask - 1);
      if (sx != sy)    x_less = sx;
      else if (magx == magy) return x;
      else if (!sx)    x_less = magx < magy;
      else             x_less = magx > magy;
      return mx ? (x_less ? y : x) : (x_less ? x : y);
   endfunction

   function automatic logic [63:0] ref_vec(input logic [63:0] a, input logic [63:0] b,
                                           input bit mx, input bit half, output bit inv);
      logic [63:0] r;
      logic [63:0] s;
      bit sn;
      int lw, h, ew, mw;
      r = '0; inv = 0;
      lw = half ? 16 : 32;
      h  = half ? 2 : 1;
      ew = half ? 5 : 8;
      mw = half ? 10 : 23;
      for (int src = 0; src < 2; src++) begin
         s = src == 0 ? a : b;
         for (int e = 0; e < h; e++) begin
            logic [31:0] v;
            v = ref_lane(32'((s >> (2*e*lw)) & ((64'd1 << lw) - 1)),
                         32'((s >> ((2*e+1)*lw)) & ((64'd1 << lw) - 1)), mx, ew, mw, sn);
            r = r | (64'(v) << ((src*h + e) * lw));
            inv = inv | sn;
         end
      end
      return r;
   endfunction

   // Issue one request and check the registered outputs one cycle later
   task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                         input bit mn, input bit half, input bit q, input bit f16);
      bit undef, inv;
      logic [63:0] exp_d;
      @(negedge clk);
      src_a = a; src_b = b; op_min = mn; size_half = half; q_bit = q; fp16_present = f16;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      undef = q || (half && !f16);
      exp_d = ref_vec(a, b, !mn, half, inv);
      if (undef) begin exp_d = '0; inv = 0; end
      check64({req, " R10 valid"}, 64'(out_valid), 64'd1);
      check64({req, " undef"}, 64'(out_undef), 64'(undef));
      check64({req, " data"}, out_data, exp_d);
      check64({req, " R7 invalid"}, 64'(out_invalid), 64'(inv));
   endtask

   task automatic test_reset();
      check64("R10 reset valid", 64'(out_valid), 64'd0);
      check64("R10 reset data", out_data, 64'd0);
      check64("R10 reset flags", {62'd0, out_undef, out_invalid}, 64'd0);
   endtask

   task automatic test_single_basic();
      // 1.0, 2.0 | -3.0, 0.5
      run_op("R1 R3 max", 64'h40000000_3F800000, 64'h3F000000_C0400000, 0, 0, 0, 1);
      check64("R1 R3 max literal", out_data, 64'h3F000000_40000000);
      run_op("R1 R3 min", 64'h40000000_3F800000, 64'h3F000000_C0400000, 1, 0, 0, 1);
      check64("R1 R3 min literal", out_data, 64'hC0400000_3F800000);
      run_op("R9 single no fp16", 64'h7F800000_FF800000, 64'h12345678_92345678, 0, 0, 0, 0);
   endtask

   task automatic test_half_basic();
      // lanes: a = {4.0, -1.0, 2.0, 1.0}, b = {inf, -inf, 0.5, -0.5}
      run_op("R2 R3 max", 64'h4400_BC00_4000_3C00, 64'h7C00_FC00_3800_B800, 0, 1, 0, 1);
      check64("R2 max literal", out_data, 64'h7C00_3800_4400_4000);
      run_op("R2 R3 min", 64'h4400_BC00_4000_3C00, 64'h7C00_FC00_3800_B800, 1, 1, 0, 1);
      check64("R2 min literal", out_data, 64'hFC00_B800_BC00_3C00);
   endtask

   task automatic test_nan();
      run_op("R4 single qnan", 64'h7FC12345_3F800000, 64'h40000000_FFFFFFFF, 0, 0, 0, 1);
      check64("R4 single literal", out_data, 64'h7FC00000_7FC00000);
      run_op("R4 half qnan", 64'h3C00_7E01_FE00_0000, 64'h1111_2222_3333_4444, 1, 1, 0, 1);
      check64("R4 half literal", out_data[31:0], 32'h7E00_7E00);
   endtask

   task automatic test_snan();
      run_op("R7 single snan", 64'h7F800001_00000000, 64'h0, 0, 0, 0, 1);
      check64("R7 single flag", 64'(out_invalid), 64'd1);
      run_op("R7 half snan", 64'h0000_0000_0000_0000, 64'h7C01_0000_0000_0000, 1, 1, 0, 1);
      check64("R7 half flag", 64'(out_invalid), 64'd1);
      // 0x7C01 upper half reads as a normal in single mode: no flag
      run_op("R7 format select", 64'h7C01_0000_3F80_0000, 64'h0, 0, 0, 0, 1);
      check64("R7 format flag", 64'(out_invalid), 64'd0);
   endtask

   task automatic test_denorm();
      run_op("R5 single", 64'hBF800000_00000001, 64'h00000000_80000005, 0, 0, 0, 1);
      check64("R5 single literal", out_data, 64'h00000000_00000000);
      run_op("R5 single min", 64'hBF800000_00000001, 64'h00000000_80000005, 1, 0, 0, 1);
      check64("R5 min literal", out_data, 64'h80000000_BF800000);
      run_op("R5 half", 64'h8001_0000_0003_BC00, 64'h0200_8000_03FF_0001, 0, 1, 0, 1);
      check64("R5 half literal", out_data, 64'h0000_0000_0000_0000);
   endtask

   task automatic test_zero();
      run_op("R6 max", 64'h00000000_80000000, 64'h80000000_00000000, 0, 0, 0, 1);
      check64("R6 max literal", out_data, 64'h00000000_00000000);
      run_op("R6 min", 64'h00000000_80000000, 64'h80000000_00000000, 1, 0, 0, 1);
      check64("R6 min literal", out_data, 64'h80000000_80000000);
      run_op("R6 half min", 64'h8000_0000_0000_8000, 64'h0, 1, 1, 0, 1);
      check64("R6 half literal", out_data[31:0], 32'h8000_8000);
   endtask

   task automatic test_undef();
      run_op("R8 q single", 64'h40000000_3F800000, 64'h7F800001_0, 0, 0, 1, 1);
      run_op("R8 q half", 64'h4400_BC00_4000_3C00, 64'h7C01_0000_0000_0000, 1, 1, 1, 1);
      run_op("R9 half no fp16", 64'h4400_BC00_4000_3C00, 64'h7C01_0000_0000_0000, 0, 1, 0, 0);
   endtask

   task automatic test_hold();
      logic [63:0] snap;
      run_op("R11 setup", 64'h7F800001_3F800000, 64'h0, 0, 0, 0, 1);
      snap = out_data;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom};
         q_bit = 1'(i); size_half = 1'(i >> 1); op_min = ~op_min;
         @(negedge clk);
         check64("R11 data held", out_data, snap);
         check64("R11 flags held", {61'd0, out_valid, out_undef, out_invalid}, 64'd1);
      end
      q_bit = 1'b0;
   endtask

   function automatic logic [15:0] pick_half();
      case ($urandom % 7)
         0: return {1'($urandom), 5'($urandom % 30 + 1), 10'($urandom)};
         1: return {1'($urandom), 5'h1F, 10'd0};
         2: return {1'($urandom), 15'd0};
         3: return {1'($urandom), 5'd0, 10'($urandom % 1023 + 1)};
         4: return {1'($urandom), 5'h1F, 1'b1, 9'($urandom)};
         5: return {1'($urandom), 5'h1F, 1'b0, 9'($urandom % 511 + 1)};
         default: return 16'($urandom);
      endcase
   endfunction

   function automatic logic [31:0] pick_single();
      case ($urandom % 7)
         0: return {1'($urandom), 8'($urandom % 254 + 1), 23'($urandom)};
         1: return {1'($urandom), 8'hFF, 23'd0};
         2: return {1'($urandom), 31'd0};
         3: return {1'($urandom), 8'd0, 23'($urandom % 8388607 + 1)};
         4: return {1'($urandom), 8'hFF, 1'b1, 22'($urandom)};
         5: return {1'($urandom), 8'hFF, 1'b0, 22'($urandom % 4194303 + 1)};
         default: return $urandom;
      endcase
   endfunction

   task automatic test_random();
      for (int i = 0; i < 300; i++) begin
         bit half;
         logic [63:0] a, b;
         half = 1'(i);
         if (half) begin
            a = {pick_half(), pick_half(), pick_half(), pick_half()};
            b = {pick_half(), pick_half(), pick_half(), pick_half()};
         end else begin
            a = {pick_single(), pick_single()};
            b = {pick_single(), pick_single()};
         end
         run_op(half ? "R2 R4 R5 random" : "R1 R4 R5 random", a, b, 1'(i >> 1), half, 0, 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_single_basic();
      test_half_basic();
      test_nan();
      test_snan();
      test_denorm();
      test_zero();
      test_undef();
      test_hold();
      test_random();
      @(negedge clk);
      check64("R10 idle valid", 64'(out_valid), 64'd0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule